// File: doc/BRIEF.md
# Byte-and-row EEPROM write controller

This block manages a small non-volatile data array of 384 bytes. The array is held as register storage inside the block, and a CPU reaches it through a 64-byte window. A bank select input chooses which 64-byte slice of the array the window shows. One control byte at a fixed bus address sets the write mode and reports when the array is programming. The array can be written one byte at a time. In row mode, up to eight bytes of one aligned row are gathered in volatile latches and then programmed in a single operation.

Each programming operation keeps the busy output high for a fixed number of clock cycles, set by a parameter. While busy is high, the control byte refuses writes and the array refuses all access. In row mode, the first accepted array write fixes the row. Later writes that fall in a different row are dropped and raise a one-cycle error pulse. The row-mode control bits clear themselves when row programming ends. A standby bit takes the array off the bus.

The CPU bus is a plain strobe interface with no back-pressure. A read strobe returns data on the next cycle. A write strobe is either taken in its own cycle or dropped silently. Busy tells software when to wait.

Top module: `nvm_row_writer`

## Requirements
- R1: After reset, the array reads FFh at every location, a control read returns 00h, busy is 0 and row_err is 0.
- R2: While the enable bit (control bit 0) is 0, array writes leave the array unchanged and do not set busy.
- R3: With enable 1, row mode off and standby off, an array write stores the byte at bank × 64 + offset. Busy goes high in the next cycle and stays high for exactly PROG_CYCLES cycles.
- R4: While busy is 1, array reads return 00h, array writes are dropped, control writes are dropped, and a control read returns 02h.
- R5: Writing the control byte with the row enable bit (bit 2) set while row mode is off empties the eight row latches. The first array write after that fixes the row (linear address bits 8..3) and fills the latch given by address bits 2..0, without setting busy.
- R6: In row mode, a write to a row other than the fixed one is dropped. row_err is 1 for exactly the cycle after that write.
- R7: The start bit (bit 3) starts row programming only when the written byte has bits 0, 2 and 3 all set and row mode was already on. Otherwise no programming starts.
- R8: Row programming keeps busy high for PROG_CYCLES cycles. It then writes all eight bytes of the row: latched bytes take their data and unwritten bytes become FFh. Row enable and start then clear, so the next array write is a byte write.
- R9: A control write that clears row enable before start abandons the row. Nothing is programmed and busy stays 0.
- R10: While the standby bit (bit 6) is 1, array reads return FFh, array writes are dropped and busy stays 0.
- R11: A bank select of 6 or more drops array writes and makes array reads return FFh.
- R12: cpu_rdata shows the result of a read in the cycle after the read strobe and is 00h in every other cycle. Reads at addresses outside the window and the control byte return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Bus address; 00h-3Fh is the window, CTRL_ADDR is the control byte |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| bank_sel | input | 3 | Selects the 64-byte slice of the array shown in the window |
| cpu_rdata | output | 8 | Read data, registered |
| busy | output | 1 | High while a programming operation runs |
| row_err | output | 1 | One-cycle pulse for a dropped off-row write in row mode |

## Verification
The main function is exercised with a lone byte write, and with a row that has only some of its bytes written over an old non-FFh value. The row case separates FFh fill from keeping the old data. An off-row write mixed into the row shows that it is dropped rather than merged. Writes made while disabled, in standby, during busy or with an out-of-range bank are each followed by readback and by a busy probe, which tells dropped writes apart from delayed ones. Start requests made with row mode off, or with enable clear, show that start is gated by the state before the write and not by the written byte alone.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  // control byte bit positions (software decodes these)
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_BUSY = 1;
  localparam int unsigned CB_PEN  = 2;
  localparam int unsigned CB_GO   = 3;
  localparam int unsigned CB_STBY = 6;
  localparam logic [7:0]  ERASED  = 8'hFF;
endpackage

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int unsigned PROG_CYCLES = 1000000,
  localparam int unsigned CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  logic [CW-1:0] cnt_q;

  assign last = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= CW'(PROG_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvm_row_latch.sv
module nvm_row_latch #(
  parameter int unsigned DW    = 8,
  parameter int unsigned LANES = 8,
  parameter logic [DW-1:0] FILL = '1,
  localparam int unsigned LW = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                we,
  input  logic [LW-1:0]       lane,
  input  logic [DW-1:0]       wdata,
  output logic [LANES*DW-1:0] row_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic          vld_q;
    logic [DW-1:0] dat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (clr) begin
        vld_q <= 1'b0;
      end else if (we && lane == LW'(g)) begin
        vld_q <= 1'b1;
        dat_q <= wdata;
      end
    end
    assign row_out[g*DW +: DW] = vld_q ? dat_q : FILL;
  end
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 384,
  parameter int unsigned LANES = 8,
  parameter logic [DW-1:0] FILL = '1,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(LANES),
  localparam int unsigned RW = AW - LW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_we,
  input  logic [AW-1:0]       byte_addr,
  input  logic [DW-1:0]       byte_data,
  input  logic                row_we,
  input  logic [RW-1:0]       row_idx,
  input  logic [LANES*DW-1:0] row_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= FILL;
    end else if (byte_we) begin
      mem[byte_addr] <= byte_data;
    end else if (row_we) begin
      for (int k = 0; k < LANES; k++)
        mem[int'(row_idx) * LANES + k] <= row_data[k*DW +: DW];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvm_row_writer.sv
module nvm_row_writer import nvm_pkg::*; #(
  parameter int unsigned DW          = 8,
  parameter int unsigned BANKS       = 6,
  parameter int unsigned WIN         = 64,
  parameter int unsigned LANES       = 8,
  parameter int unsigned ABW         = 8,
  parameter logic [ABW-1:0] CTRL_ADDR = 8'hEA,
  parameter int unsigned PROG_CYCLES = 1000000,
  localparam int unsigned DEPTH = BANKS * WIN,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned OW    = $clog2(WIN),
  localparam int unsigned BW    = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int unsigned LW    = $clog2(LANES),
  localparam int unsigned RW    = AW - LW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [ABW-1:0] cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  input  logic           cpu_rd,
  input  logic           cpu_wr,
  input  logic [BW-1:0]  bank_sel,
  output logic [DW-1:0]  cpu_rdata,
  output logic           busy,
  output logic           row_err
);
  logic en_q, pen_q, go_q, stby_q, locked_q;
  logic [RW-1:0] row_q;
  logic tmr_last;

  // address decode
  logic ctrl_hit, win_hit, bank_ok;
  logic [AW-1:0] lin;
  logic [RW-1:0] lin_row;
  assign ctrl_hit = (cpu_addr == CTRL_ADDR);
  assign win_hit  = (32'(cpu_addr) < WIN);
  assign bank_ok  = (32'(bank_sel) < BANKS);
  assign lin      = AW'(bank_sel) * AW'(WIN) + AW'(cpu_addr[OW-1:0]);
  assign lin_row  = lin[AW-1:LW];

  // access qualification
  logic wr_ctrl, wr_arr, byte_start, row_wr, row_bad, go_req, commit, latch_clr;
  assign wr_ctrl    = cpu_wr && ctrl_hit && !busy;
  assign wr_arr     = cpu_wr && win_hit && bank_ok && en_q && !stby_q && !busy;
  assign byte_start = wr_arr && !pen_q;
  assign row_wr     = wr_arr && pen_q && (!locked_q || lin_row == row_q);
  assign row_bad    = wr_arr && pen_q && locked_q && (lin_row != row_q);
  assign go_req     = wr_ctrl && pen_q && cpu_wdata[CB_EN] && cpu_wdata[CB_PEN] && cpu_wdata[CB_GO];
  assign commit     = tmr_last && go_q;
  assign latch_clr  = (wr_ctrl && !(pen_q && cpu_wdata[CB_PEN])) || commit;

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pen_q    <= 1'b0;
      go_q     <= 1'b0;
      stby_q   <= 1'b0;
      locked_q <= 1'b0;
      row_q    <= '0;
      row_err  <= 1'b0;
    end else begin
      row_err <= row_bad;
      if (wr_ctrl) begin
        en_q   <= cpu_wdata[CB_EN];
        stby_q <= cpu_wdata[CB_STBY];
      end
      if (commit) begin
        pen_q <= 1'b0;
        go_q  <= 1'b0;
      end else begin
        if (wr_ctrl) pen_q <= cpu_wdata[CB_PEN];
        if (go_req)  go_q  <= 1'b1;
      end
      if (latch_clr) begin
        locked_q <= 1'b0;
      end else if (row_wr && !locked_q) begin
        locked_q <= 1'b1;
        row_q    <= lin_row;
      end
    end
  end

  nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(byte_start || go_req),
    .busy(busy), .last(tmr_last)
  );

  logic [LANES*DW-1:0] row_data;
  nvm_row_latch #(.DW(DW), .LANES(LANES), .FILL(DW'(ERASED))) lat_i (
    .clk(clk), .rst_n(rst_n), .clr(latch_clr), .we(row_wr),
    .lane(lin[LW-1:0]), .wdata(cpu_wdata), .row_out(row_data)
  );

  logic [DW-1:0] mem_rd;
  nvm_store #(.DW(DW), .DEPTH(DEPTH), .LANES(LANES), .FILL(DW'(ERASED))) st_i (
    .clk(clk), .rst_n(rst_n),
    .byte_we(byte_start), .byte_addr(lin), .byte_data(cpu_wdata),
    .row_we(commit && locked_q), .row_idx(row_q), .row_data(row_data),
    .rd_addr(bank_ok ? lin : '0), .rd_data(mem_rd)
  );

  // read path
  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (cpu_rd) begin
      if (ctrl_hit) begin
        rd_next[CB_BUSY] = busy;
      end else if (win_hit) begin
        if (busy)                  rd_next = '0;
        else if (stby_q || !bank_ok) rd_next = DW'(ERASED);
        else                       rd_next = mem_rd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_rdata <= '0;
    else        cpu_rdata <= rd_next;
  end
endmodule

// File: rtl/nvm_row_writer_chk.sv
module nvm_row_writer_chk #(
  parameter int unsigned PROG_CYCLES = 1000000,
  parameter int unsigned RW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr,
  input logic          win_hit,
  input logic          en_q,
  input logic          pen_q,
  input logic          go_q,
  input logic          stby_q,
  input logic          busy,
  input logic          tmr_last,
  input logic          locked_q,
  input logic [RW-1:0] row_q
);
  int unsigned run_c;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_c <= 0;
    else if (busy) run_c <= run_c + 1;
    else           run_c <= 0;
  end

  a_r2_disabled_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && win_hit && !en_q && !busy) |=> !busy);

  a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_c < PROG_CYCLES);

  a_r3_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_c == PROG_CYCLES);

  a_r4_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tmr_last && cpu_wr) |=> $stable({en_q, pen_q, go_q, stby_q}));

  a_r5_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && $past(locked_q)) |-> $stable(row_q));

  a_r7_go_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> ($past(pen_q) && en_q));

  a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_last && go_q) |=> (!pen_q && !go_q));
endmodule

bind nvm_row_writer nvm_row_writer_chk #(.PROG_CYCLES(PROG_CYCLES), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .win_hit(win_hit),
  .en_q(en_q), .pen_q(pen_q), .go_q(go_q), .stby_q(stby_q),
  .busy(busy), .tmr_last(tmr_last), .locked_q(locked_q), .row_q(row_q)
);

// File: tb/nvm_row_writer_tb_top.sv
`timescale 1ns/1ps
module nvm_row_writer_tb_top;
  localparam int P = 37;
  localparam logic [7:0] CTRL = 8'hEA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_rd = 1'b0;
  logic cpu_wr = 1'b0;
  logic [2:0] bank_sel = '0;
  logic [7:0] cpu_rdata;
  logic busy, row_err;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvm_row_writer #(.PROG_CYCLES(P), .CTRL_ADDR(CTRL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .bank_sel(bank_sel),
    .cpu_rdata(cpu_rdata), .busy(busy), .row_err(row_err)
  );

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %02h exp %02h", tag, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [384];
  logic [7:0] m_lat [8];
  bit m_val [8];
  bit m_en, m_pe, m_sb, m_go, m_busy, m_lock, m_err;
  int m_cnt, m_row, lin;
  logic [7:0] m_rd, nrd;
  bit nerr;

  task automatic m_clear_row();
    for (int k = 0; k < 8; k++) m_val[k] = 1'b0;
    m_lock = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 384; i++) m_mem[i] = 8'hFF;
      m_clear_row();
      m_en = 0; m_pe = 0; m_sb = 0; m_go = 0; m_busy = 0; m_cnt = 0;
      m_rd = 8'h00; m_err = 0; m_row = 0;
    end else begin
      nrd = 8'h00; nerr = 0;
      lin = int'(bank_sel) * 64 + int'(cpu_addr);
      if (cpu_rd) begin
        if (cpu_addr == CTRL) nrd = m_busy ? 8'h02 : 8'h00;
        else if (cpu_addr < 8'd64) begin
          if (m_busy) nrd = 8'h00;
          else if (m_sb || bank_sel >= 3'd6) nrd = 8'hFF;
          else nrd = m_mem[lin];
        end
      end
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy = 0;
          if (m_go) begin
            if (m_lock)
              for (int k = 0; k < 8; k++) m_mem[m_row*8+k] = m_val[k] ? m_lat[k] : 8'hFF;
            m_clear_row();
            m_pe = 0; m_go = 0;
          end
        end else m_cnt--;
      end else if (cpu_wr) begin
        if (cpu_addr == CTRL) begin
          if (cpu_wdata[0] && cpu_wdata[2] && cpu_wdata[3] && m_pe) begin
            m_go = 1; m_busy = 1; m_cnt = P;
          end
          if (!(m_pe && cpu_wdata[2])) m_clear_row();
          m_en = cpu_wdata[0]; m_pe = cpu_wdata[2]; m_sb = cpu_wdata[6];
        end else if (cpu_addr < 8'd64 && bank_sel < 3'd6 && m_en && !m_sb) begin
          if (!m_pe) begin
            m_mem[lin] = cpu_wdata; m_busy = 1; m_cnt = P;
          end else if (!m_lock || lin / 8 == m_row) begin
            m_lock = 1; m_row = lin / 8;
            m_val[lin % 8] = 1; m_lat[lin % 8] = cpu_wdata;
          end else nerr = 1;
        end
      end
      m_rd = nrd; m_err = nerr;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "model busy", {7'b0, busy}, {7'b0, m_busy});
      chk("R12", "model rdata", cpu_rdata, m_rd);
      chk("R6", "model row_err", {7'b0, row_err}, {7'b0, m_err});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [7:0] a, logic [7:0] d, logic [2:0] b);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; bank_sel = b; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [2:0] b, output logic [7:0] v);
    @(negedge clk);
    cpu_addr = a; bank_sel = b; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    v = cpu_rdata;
  endtask

  task automatic rchk(string tag, logic [7:0] a, logic [2:0] b, logic [7:0] exp);
    logic [7:0] v;
    rd(a, b, v);
    chk(tag, "read", v, exp);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_err++;
      $display("FAIL R1 watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", "busy", {7'b0, busy}, 8'h00);
    chk("R1", "row_err", {7'b0, row_err}, 8'h00);
    rchk("R1", CTRL, 3'd0, 8'h00);
    rchk("R1", 8'h00, 3'd0, 8'hFF);

    // R2 disabled writes
    wr(8'h05, 8'h5A, 3'd2);
    chk("R2", "busy", {7'b0, busy}, 8'h00);
    rchk("R2", 8'h05, 3'd2, 8'hFF);

    // R3 byte write and busy length
    wr(CTRL, 8'h01, 3'd0);
    wr(8'h05, 8'h5A, 3'd2);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R3", "busy cycles", 8'(n), 8'(P));
    rchk("R3", 8'h05, 3'd2, 8'h5A);

    // R4 busy blocking
    wr(8'h00, 8'h33, 3'd1);
    rchk("R4", CTRL, 3'd0, 8'h02);
    rchk("R4", 8'h05, 3'd2, 8'h00);
    wr(8'h01, 8'h77, 3'd1);
    wr(CTRL, 8'h00, 3'd0);
    wait_idle();
    rchk("R4", 8'h01, 3'd1, 8'hFF);
    rchk("R4", 8'h00, 3'd1, 8'h33);
    wr(8'h02, 8'h44, 3'd1);
    chk("R4", "enable kept", {7'b0, busy}, 8'h01);
    wait_idle();

    // R5 / R6 row collection on row of bank 2 offsets 0..7
    wr(CTRL, 8'h05, 3'd0);
    wr(8'h01, 8'hA1, 3'd2);
    chk("R5", "no busy", {7'b0, busy}, 8'h00);
    wr(8'h04, 8'hA4, 3'd2);
    wr(8'h14, 8'hEE, 3'd2);
    chk("R6", "row_err pulse", {7'b0, row_err}, 8'h01);
    @(negedge clk);
    chk("R6", "row_err one cycle", {7'b0, row_err}, 8'h00);

    // R7 start without enable is ignored
    wr(CTRL, 8'h0C, 3'd0);
    chk("R7", "no start", {7'b0, busy}, 8'h00);
    // R8 start
    wr(CTRL, 8'h0D, 3'd0);
    chk("R8", "start busy", {7'b0, busy}, 8'h01);
    wait_idle();
    rchk("R8", 8'h00, 3'd2, 8'hFF);
    rchk("R8", 8'h01, 3'd2, 8'hA1);
    rchk("R8", 8'h04, 3'd2, 8'hA4);
    rchk("R8", 8'h05, 3'd2, 8'hFF);
    rchk("R6", 8'h14, 3'd2, 8'hFF);
    wr(8'h1E, 8'h1E, 3'd3);
    chk("R8", "back to byte mode", {7'b0, busy}, 8'h01);
    wait_idle();
    rchk("R8", 8'h1E, 3'd3, 8'h1E);

    // R9 abandon, R7 start with row mode off
    wr(CTRL, 8'h05, 3'd0);
    wr(8'h00, 8'hC3, 3'd4);
    wr(CTRL, 8'h01, 3'd0);
    chk("R9", "no busy", {7'b0, busy}, 8'h00);
    wr(CTRL, 8'h0D, 3'd0);
    chk("R7", "start needs prior row mode", {7'b0, busy}, 8'h00);
    wr(CTRL, 8'h01, 3'd0);
    rchk("R9", 8'h00, 3'd4, 8'hFF);

    // R10 standby
    wr(CTRL, 8'h41, 3'd0);
    rchk("R10", 8'h00, 3'd1, 8'hFF);
    wr(8'h03, 8'h99, 3'd0);
    chk("R10", "no busy", {7'b0, busy}, 8'h00);
    wr(CTRL, 8'h01, 3'd0);
    rchk("R10", 8'h00, 3'd1, 8'h33);
    rchk("R10", 8'h03, 3'd0, 8'hFF);

    // R11 bank out of range
    wr(8'h00, 8'h55, 3'd6);
    chk("R11", "no busy", {7'b0, busy}, 8'h00);
    rchk("R11", 8'h00, 3'd6, 8'hFF);
    rchk("R11", 8'h3F, 3'd7, 8'hFF);

    // R12 other addresses
    rchk("R12", 8'h80, 3'd0, 8'h00);
    @(negedge clk);
    chk("R12", "idle rdata", cpu_rdata, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule